// File: doc/BRIEF.md
# Two-Stage Multi-Request Output Arbiter

This block arbitrates the outputs of a 16x16 crossbar. Each input port can post one request vector with a bit set for every output it would accept, for example one bit per virtual output queue or per priority queue. Arbitration takes two word-clock stages. In the first stage, each requested output that is neither connected nor reserved is reserved for one requester, and a rotating port pointer settles any contention. In the second stage, each port that reserved anything keeps one output as its connection and returns the rest to the free pool. The keeper is chosen by a per-port rotating queue pointer.

A request that reserves nothing stays pending inside the block. It is offered again on every cycle until it wins. When a grant is made, the port sees a one-cycle acknowledge pulse. On the next cycle it sees the granted output index. The connection holds its output until a release strobe names that output.

Top module: `mq_arbiter`

## Requirements
- R1: A synchronous reset frees all outputs, clears all pending and reserved requests, drops all acknowledges and sets every rotating pointer to zero.
- R2: A request vector is taken only when its port has no pending request, no reservation and no connection, and only when the vector is nonzero. Otherwise it is ignored: no acknowledge follows, and the connection map is unchanged.
- R3: In the first stage, each output that is requested and is neither connected nor reserved is reserved for exactly one requester. No output is ever connected to two ports, and no output is both reserved and connected.
- R4: In the second stage, the port keeps the first reserved output found by scanning upward, cyclically, from its queue pointer. Its queue pointer then becomes that index plus one, modulo 16. The port's other reserved outputs are free on the following cycle.
- R5: If a request vector is presented in the cycle before clock edge k, the port's acknowledge is high for exactly the one cycle between edges k+1 and k+2. In the next cycle, num_vld is high and the output index appears on num_bus bits [4p+3:4p] for port p.
- R6: A request that reserves nothing is kept and offered again on every later cycle until it is granted. It is never dropped.
- R7: A connected output stays busy until rel_valid is high with rel_out equal to its index. It is free from the following clock edge onward. A release naming an output that is not busy has no effect.
- R8: Contested outputs go to the first requesting port found by scanning upward, cyclically, from the port pointer. After any cycle with grants, the port pointer becomes one past the first granted port in that same cyclic order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous reset, active high |
| req_load | input | 16 | Per-port strobe: take the request vector |
| req_mask | input | 256 | Request vectors, port p in bits [16p+15:16p] |
| rel_valid | input | 1 | Release strobe |
| rel_out | input | 4 | Output index to release |
| ack | output | 16 | Per-port grant acknowledge pulse |
| num_vld | output | 16 | Per-port granted-index valid, one cycle after ack |
| num_bus | output | 64 | Granted output index, port p in bits [4p+3:4p] |
| out_busy | output | 16 | Per-output connected flag |

## Verification
The hardest state to reach is a port that reserved several outputs in stage one while its queue pointer sits between them, so that the cyclic wrap decides the winner. A directed sequence builds this state. It grants port 9 one output to move its pointer, releases that output, and then asks for the same pair again. A second hard case is a pending request that waits on a busy output until a release arrives. Long random runs, with sparse loads, multi-bit masks and releases aimed at random outputs (busy or not), bring about contention, re-arbitration and ignored releases. Each cycle is compared against a reference model kept in the bench.

// File: rtl/mq_arbiter.sv
module mq_arbiter #(
  parameter int NPORT = 16,
  parameter int NOUT  = 16,
  localparam int OW = (NOUT  > 1) ? $clog2(NOUT)  : 1,
  localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NPORT-1:0]      req_load,
  input  logic [NPORT*NOUT-1:0] req_mask,
  input  logic                  rel_valid,
  input  logic [OW-1:0]         rel_out,
  output logic [NPORT-1:0]      ack,
  output logic [NPORT-1:0]      num_vld,
  output logic [NPORT*OW-1:0]   num_bus,
  output logic [NOUT-1:0]       out_busy
);

  logic [NPORT-1:0] pend, hv, conn, ack_q, nv_q;
  logic [NOUT-1:0]  pmask [NPORT];
  logic [NOUT-1:0]  hold  [NPORT];
  logic [NOUT-1:0]  eff   [NPORT];
  logic [NOUT-1:0]  win1  [NPORT];
  logic [OW-1:0]    cout  [NPORT];
  logic [OW-1:0]    qptr  [NPORT];
  logic [OW-1:0]    w2    [NPORT];
  logic [PW-1:0]    pptr, gp;
  logic             anyg;
  logic [NOUT-1:0]  busy, held, free;

  always_comb begin
    busy = '0;
    held = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (conn[p]) busy[cout[p]] = 1'b1;
      if (hv[p])   held = held | hold[p];
    end
  end

  assign free = ~busy & ~held;

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      if (pend[p])
        eff[p] = pmask[p];
      else if (req_load[p] && !hv[p] && !conn[p])
        eff[p] = req_mask[p*NOUT +: NOUT];
      else
        eff[p] = '0;
    end
  end

  always_comb begin
    logic taken;
    int   p;
    for (int i = 0; i < NPORT; i++) win1[i] = '0;
    for (int o = 0; o < NOUT; o++) begin
      taken = 1'b0;
      for (int k = 0; k < NPORT; k++) begin
        p = (int'(pptr) + k) % NPORT;
        if (!taken && free[o] && eff[p][o]) begin
          win1[p][o] = 1'b1;
          taken = 1'b1;
        end
      end
    end
  end

  always_comb begin
    logic found;
    int   o;
    for (int p = 0; p < NPORT; p++) begin
      w2[p] = '0;
      found = 1'b0;
      for (int k = 0; k < NOUT; k++) begin
        o = (int'(qptr[p]) + k) % NOUT;
        if (!found && hold[p][o]) begin
          w2[p] = OW'(o);
          found = 1'b1;
        end
      end
    end
  end

  always_comb begin
    int p;
    anyg = 1'b0;
    gp   = '0;
    for (int k = 0; k < NPORT; k++) begin
      p = (int'(pptr) + k) % NPORT;
      if (!anyg && hv[p]) begin
        gp   = PW'(p);
        anyg = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend  <= '0;
      hv    <= '0;
      conn  <= '0;
      ack_q <= '0;
      nv_q  <= '0;
      pptr  <= '0;
      for (int p = 0; p < NPORT; p++) begin
        pmask[p] <= '0;
        hold[p]  <= '0;
        cout[p]  <= '0;
        qptr[p]  <= '0;
      end
    end else begin
      ack_q <= hv;
      nv_q  <= ack_q;
      if (anyg) pptr <= PW'((int'(gp) + 1) % NPORT);
      for (int p = 0; p < NPORT; p++) begin
        if (hv[p]) begin
          hv[p]   <= 1'b0;
          conn[p] <= 1'b1;
          cout[p] <= w2[p];
          qptr[p] <= OW'((int'(w2[p]) + 1) % NOUT);
        end else if (|win1[p]) begin
          hv[p]   <= 1'b1;
          hold[p] <= win1[p];
          pend[p] <= 1'b0;
        end else if (|eff[p]) begin
          pend[p]  <= 1'b1;
          pmask[p] <= eff[p];
        end
        if (conn[p] && rel_valid && cout[p] == rel_out) conn[p] <= 1'b0;
      end
    end
  end

  assign ack      = ack_q;
  assign num_vld  = nv_q;
  assign out_busy = busy;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign num_bus[p*OW +: OW] = cout[p];

    // R5
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      ack[p] |=> !ack[p]);

    // R4
    stage2_chk: assert property (@(posedge clk) disable iff (rst)
      hv[p] |=> (ack[p] && out_busy[cout[p]]));

    // R6
    pend_keep_chk: assert property (@(posedge clk) disable iff (rst)
      pend[p] |=> (pend[p] || hv[p]));
  end

  logic [NPORT-1:0] own [NOUT];
  always_comb begin
    for (int o = 0; o < NOUT; o++)
      for (int p = 0; p < NPORT; p++)
        own[o][p] = conn[p] && (int'(cout[p]) == o);
  end

  for (genvar o = 0; o < NOUT; o++) begin : g_out
    // R3
    one_owner_chk: assert property (@(posedge clk) disable iff (rst)
      $countones(own[o]) <= 1);
  end

  // R3
  held_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (held & busy) == '0);

  // R7
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (rel_valid && out_busy[rel_out]) |=> !out_busy[$past(rel_out)]);

endmodule

// File: tb/test_mq_arbiter.sv
`timescale 1ns/1ps
module test_mq_arbiter;
  localparam int NP = 16;
  localparam int NO = 16;
  localparam int OW = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NP-1:0]     ld = '0;
  logic [NP*NO-1:0]  mk = '0;
  logic              rv = 1'b0;
  logic [OW-1:0]     ro = '0;
  logic [NP-1:0]     ack, nv;
  logic [NP*OW-1:0]  nb;
  logic [NO-1:0]     busy;

  always #2.5 clk = ~clk;

  mq_arbiter #(.NPORT(NP), .NOUT(NO)) i_mq_arbiter (
    .clk(clk), .rst(rst), .req_load(ld), .req_mask(mk),
    .rel_valid(rv), .rel_out(ro), .ack(ack), .num_vld(nv),
    .num_bus(nb), .out_busy(busy));

  int checks = 0, errors = 0;
  bit done = 0;

  bit [NP-1:0]  m_pend, m_hv, m_conn, m_ack, m_nv;
  bit [NO-1:0]  m_mask [NP];
  bit [NO-1:0]  m_hold [NP];
  int           m_cout [NP];
  int           m_q    [NP];
  int           m_pp;
  bit [NP-1:0]  n_pend, n_hv, n_conn, n_ack, n_nv;
  bit [NO-1:0]  n_mask [NP];
  bit [NO-1:0]  n_hold [NP];
  int           n_cout [NP];
  int           n_q    [NP];
  int           n_pp;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit [NO-1:0] m_busy();
    bit [NO-1:0] b = '0;
    for (int p = 0; p < NP; p++) if (m_conn[p]) b[m_cout[p]] = 1'b1;
    return b;
  endfunction

  task automatic model_reset();
    m_pend = '0; m_hv = '0; m_conn = '0; m_ack = '0; m_nv = '0; m_pp = 0;
    for (int p = 0; p < NP; p++) begin
      m_mask[p] = '0; m_hold[p] = '0; m_cout[p] = 0; m_q[p] = 0;
    end
  endtask

  task automatic model_next();
    bit [NO-1:0] bz, hd, fr;
    bit [NO-1:0] eff [NP];
    bit [NO-1:0] win [NP];
    int first, w;
    bz = m_busy();
    hd = '0;
    for (int p = 0; p < NP; p++) if (m_hv[p]) hd |= m_hold[p];
    fr = ~bz & ~hd;
    for (int p = 0; p < NP; p++) begin
      if (m_pend[p]) eff[p] = m_mask[p];
      else if (ld[p] && !m_hv[p] && !m_conn[p]) eff[p] = mk[p*NO +: NO];
      else eff[p] = '0;
      win[p] = '0;
    end
    for (int o = 0; o < NO; o++)
      for (int k = 0; k < NP; k++) begin
        int p = (m_pp + k) % NP;
        if (fr[o] && eff[p][o]) begin win[p][o] = 1'b1; break; end
      end
    n_pend = m_pend; n_hv = m_hv; n_conn = m_conn; n_pp = m_pp;
    n_ack = m_hv; n_nv = m_ack;
    for (int p = 0; p < NP; p++) begin
      n_mask[p] = m_mask[p]; n_hold[p] = m_hold[p];
      n_cout[p] = m_cout[p]; n_q[p] = m_q[p];
    end
    first = -1;
    for (int k = 0; k < NP; k++) begin
      int p = (m_pp + k) % NP;
      if (m_hv[p]) begin first = p; break; end
    end
    if (first >= 0) n_pp = (first + 1) % NP;
    for (int p = 0; p < NP; p++) begin
      if (m_hv[p]) begin
        w = 0;
        for (int k = 0; k < NO; k++) begin
          int o = (m_q[p] + k) % NO;
          if (m_hold[p][o]) begin w = o; break; end
        end
        n_hv[p] = 1'b0; n_conn[p] = 1'b1; n_cout[p] = w; n_q[p] = (w + 1) % NO;
      end else if (win[p] != 0) begin
        n_hv[p] = 1'b1; n_hold[p] = win[p]; n_pend[p] = 1'b0;
      end else if (eff[p] != 0) begin
        n_pend[p] = 1'b1; n_mask[p] = eff[p];
      end
      if (m_conn[p] && rv && m_cout[p] == int'(ro)) n_conn[p] = 1'b0;
    end
  endtask

  task automatic compare_all();
    chk(busy == m_busy(), "R3/R7 busy map", int'(busy), int'(m_busy()));
    chk(ack == m_ack, "R5 ack", int'(ack), int'(m_ack));
    chk(nv == m_nv, "R5 num_vld", int'(nv), int'(m_nv));
    for (int p = 0; p < NP; p++)
      if (m_nv[p]) chk(int'(nb[p*OW +: OW]) == m_cout[p], "R4 granted index",
                       int'(nb[p*OW +: OW]), m_cout[p]);
  endtask

  task automatic tick();
    model_next();
    @(posedge clk);
    m_pend = n_pend; m_hv = n_hv; m_conn = n_conn; m_ack = n_ack; m_nv = n_nv; m_pp = n_pp;
    for (int p = 0; p < NP; p++) begin
      m_mask[p] = n_mask[p]; m_hold[p] = n_hold[p]; m_cout[p] = n_cout[p]; m_q[p] = n_q[p];
    end
    @(negedge clk);
    compare_all();
    ld = '0; rv = 1'b0;
  endtask

  task automatic req(input int p, input bit [NO-1:0] m);
    ld[p] = 1'b1;
    mk[p*NO +: NO] = m;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(busy == '0, "R1 busy after reset", int'(busy), 0);
    chk(ack == '0, "R1 ack after reset", int'(ack), 0);
    chk(nv == '0, "R1 num_vld after reset", int'(nv), 0);

    // R5 / R4: port 3 asks for outputs 5 and 9
    req(3, 16'h0220);
    tick();
    chk(ack[3] == 1'b0, "R5 early ack", ack[3], 0);
    tick();
    chk(ack[3] == 1'b1, "R5 ack two cycles after request", ack[3], 1);
    tick();
    chk(nv[3] == 1'b1, "R5 num_vld follows ack", nv[3], 1);
    chk(int'(nb[12 +: 4]) == 5, "R4 lowest from pointer 0", int'(nb[12 +: 4]), 5);
    chk(busy == 16'h0020, "R4 other reserved output freed", int'(busy), 32);

    // R2: connected port ignores a new vector
    req(3, 16'h0004);
    tick(); tick();
    chk(ack[3] == 1'b0, "R2 load ignored while connected", ack[3], 0);
    tick();
    chk(busy[2] == 1'b0, "R2 ignored vector left output 2 free", busy[2], 0);

    // R6 / R7: port 7 waits on busy output 5
    req(7, 16'h0020);
    for (int i = 0; i < 5; i++) begin
      tick();
      chk(ack[7] == 1'b0, "R6 blocked request waits", ack[7], 0);
    end
    rv = 1'b1; ro = 4'd9;
    tick();
    chk(busy == 16'h0020, "R7 release of free output ignored", int'(busy), 32);
    rv = 1'b1; ro = 4'd5;
    tick();
    chk(busy[5] == 1'b0, "R7 released output free", busy[5], 1'b0);
    tick();
    tick();
    chk(ack[7] == 1'b1, "R6 retried request granted", ack[7], 1);

    // R8: pointer now 8, ports 1 and 2 contend for output 0
    req(1, 16'h0001); req(2, 16'h0001);
    tick(); tick();
    chk(ack[1] == 1'b1, "R8 rotating pointer picks port 1", ack[1], 1);
    chk(ack[2] == 1'b0, "R8 port 2 loses", ack[2], 0);

    // R2: zero vector ignored
    req(4, 16'h0000);
    tick(); tick();
    chk(ack[4] == 1'b0, "R2 zero vector ignored", ack[4], 0);

    // R4: queue pointer wrap for port 9
    req(9, 16'h1400);
    tick(); tick(); tick();
    chk(int'(nb[36 +: 4]) == 10, "R4 first grant from pointer 0", int'(nb[36 +: 4]), 10);
    rv = 1'b1; ro = 4'd10;
    tick();
    req(9, 16'h1400);
    tick(); tick(); tick();
    chk(nv[9] == 1'b1, "R5 second grant index valid", nv[9], 1);
    chk(int'(nb[36 +: 4]) == 12, "R4 pointer 11 selects 12", int'(nb[36 +: 4]), 12);

    // random mix
    for (int c = 0; c < 4000; c++) begin
      for (int p = 0; p < NP; p++)
        if ($urandom_range(0, 7) == 0) begin
          bit [NO-1:0] m = '0;
          int nb_bits = $urandom_range(0, 3);
          for (int b = 0; b < nb_bits; b++) m[$urandom_range(0, NO-1)] = 1'b1;
          req(p, m);
        end
      if ($urandom_range(0, 2) == 0) begin
        rv = 1'b1;
        ro = OW'($urandom_range(0, NO-1));
      end
      tick();
    end

    rst = 1'b1;
    @(posedge clk);
    model_reset();
    @(negedge clk);
    rst = 1'b0;
    chk(busy == '0, "R1 second reset clears map", int'(busy), 0);
    chk(ack == '0, "R1 second reset clears ack", int'(ack), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule